// File: doc/BRIEF.md
# Selectable-Period Watchdog Supervisor

This block is the watchdog half of a CPU supervisor. A free-running millisecond timebase, scaled from the system clock by a ticks-per-millisecond parameter, advances a watchdog count. A 3-bit code picks one of seven timeout periods, or turns the watchdog off. The host proves it is alive by pulling the serial data line low for at least a minimum number of clock cycles. Any such low episode restarts the count. If the count reaches the selected period first, the block drives its CPU reset output for a fixed reset timeout.

A digital low-voltage input stands in for the analog supply comparator. While it is high, reset is held. Once it falls, reset stays asserted for the same reset timeout before it releases. A volatile status flag with a cause bit records whether the most recent reset came from the watchdog or from low voltage. The flag stays set until the host clears it or a power-on reset occurs.

Top module: `wdt_supervisor`

## Requirements
- R1: Each period code selects a timeout. The codes are 000 = 150 ms, 001 = 450 ms, 010 = 1 s, 011 = 5 s, 100 = 10 s, 101 = 20 s and 110 = 60 s. Without a restart, `cpu_rst_o` rises exactly period × TICKS_PER_MS clock cycles after it last fell (the bench uses TICKS_PER_MS = 1).
- R2: Code 111 disables the watchdog, so `cpu_rst_o` never rises from a timeout.
- R3: Holding `sda_i` low for at least KICK_MIN_CYC consecutive cycles restarts the watchdog count from zero. Shorter low pulses have no effect on when the timeout happens.
- R4: A watchdog timeout raises `cpu_rst_o` on the next clock edge. It then holds `cpu_rst_o` high for RST_MS × TICKS_PER_MS cycles before releasing it. `cpu_rst_o` never falls in the cycle after `low_volt_i` was high.
- R5: A high `low_volt_i` raises `cpu_rst_o` on the next edge and holds it while the input stays high. After the input falls, `cpu_rst_o` stays high for about RST_MS more milliseconds (within one tick).
- R6: A watchdog timeout sets `rst_flag_o` to 1 and `wdt_cause_o` to 1.
- R7: Low voltage sets `rst_flag_o` to 1 and `wdt_cause_o` to 0. Low voltage wins over a watchdog timeout in the same cycle.
- R8: `rst_flag_o` and `wdt_cause_o` clear only on a `flag_clr_i` pulse with no set event in the same cycle, or on `rst`. Otherwise they hold their value.
- R9: A change of `period_sel` restarts the count from zero under the new period.
- R10: The watchdog count is held at zero while `cpu_rst_o` is high. A full period therefore runs after reset releases, however long the reset lasted.
- R11: During and after the synchronous `rst`, `cpu_rst_o` is 1 and both flags are 0. `cpu_rst_o` releases about RST_MS milliseconds after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| period_sel | input | 3 | Watchdog period code |
| sda_i | input | 1 | Serial data line, asynchronous; a long low restarts the watchdog |
| low_volt_i | input | 1 | Low-supply indication |
| flag_clr_i | input | 1 | Host write that clears the status flag |
| cpu_rst_o | output | 1 | Registered CPU reset, active high |
| rst_flag_o | output | 1 | A supervisor reset has occurred since the last clear |
| wdt_cause_o | output | 1 | 1 = last reset from watchdog, 0 = from low voltage |

## Verification
The properties assume that `period_sel` changes only between clock edges and that `low_volt_i` and `flag_clr_i` are synchronous to `clk`. Only `sda_i` is treated as asynchronous, and it passes through a synchronizer. The stimulus drives every input on the falling edge. Glitch widths are drawn from $urandom and kept at most two cycles, which stays below the restart threshold. Long lows are drawn at the threshold or a few cycles beyond it. Timeout intervals are measured from the falling edge of `cpu_rst_o`, so each period is checked cycle-exactly against a bench table of the code mapping.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_MAX_MS = 60000;
  localparam logic [2:0]  WDT_CODE_OFF = 3'b111;

  // period in milliseconds for each code; 0 means disabled
  function automatic int unsigned wdt_period_ms(input logic [2:0] code);
    case (code)
      3'd0:    return 150;
      3'd1:    return 450;
      3'd2:    return 1000;
      3'd3:    return 5000;
      3'd4:    return 10000;
      3'd5:    return 20000;
      3'd6:    return 60000;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned TICKS_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned TB_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  logic [TB_W-1:0] div_q;

  assign tick_o = (div_q == TB_W'(TICKS_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_kick_detect.sv
module wdt_kick_detect #(
  parameter int unsigned KICK_MIN_CYC = 125,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_i,
  output logic kick_o
);
  localparam int unsigned KW = $clog2(KICK_MIN_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [KW-1:0]          low_q;
  logic                   sda_s;

  // synchronizer chain; line idles high
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else     sync_q[g] <= (g == 0) ? sda_i : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sda_s  = sync_q[SYNC_STAGES-1];
  // one pulse per low episode, when it reaches the minimum length
  assign kick_o = !sda_s && (low_q == KW'(KICK_MIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || sda_s)                   low_q <= '0;
    else if (low_q != KW'(KICK_MIN_CYC)) low_q <= low_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [2:0]       sel_i,
  input  logic             kick_i,
  input  logic             hold_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [2:0]  sel_q;
  logic        chg;
  logic        off;
  int unsigned limit;

  assign chg   = (sel_i != sel_q);
  assign off   = (sel_q == WDT_CODE_OFF);
  assign limit = wdt_period_ms(sel_q);

  assign expire_o = tick_i && !off && !hold_i && !kick_i && !chg &&
                    (32'(cnt_o) == limit - 1);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= WDT_CODE_OFF;
    else     sel_q <= sel_i;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i || kick_i || chg || off) cnt_o <= '0;
    else if (expire_o)                          cnt_o <= '0;
    else if (tick_i)                            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int unsigned RST_MS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic expire_i,
  input  logic low_volt_i,
  input  logic flag_clr_i,
  output logic cpu_rst_o,
  output logic rst_flag_o,
  output logic wdt_cause_o
);
  localparam int unsigned HW = $clog2(RST_MS + 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rst_o <= 1'b1;
      hold_q    <= '0;
    end else if (low_volt_i || expire_i) begin
      cpu_rst_o <= 1'b1;
      hold_q    <= '0;
    end else if (cpu_rst_o && tick_i) begin
      if (hold_q == HW'(RST_MS - 1)) begin
        cpu_rst_o <= 1'b0;
        hold_q    <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_flag_o  <= 1'b0;
      wdt_cause_o <= 1'b0;
    end else if (low_volt_i) begin
      rst_flag_o  <= 1'b1;
      wdt_cause_o <= 1'b0;
    end else if (expire_i) begin
      rst_flag_o  <= 1'b1;
      wdt_cause_o <= 1'b1;
    end else if (flag_clr_i) begin
      rst_flag_o  <= 1'b0;
      wdt_cause_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 125000,
  parameter int unsigned RST_MS       = 200,
  parameter int unsigned KICK_MIN_CYC = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] period_sel,
  input  logic       sda_i,
  input  logic       low_volt_i,
  input  logic       flag_clr_i,
  output logic       cpu_rst_o,
  output logic       rst_flag_o,
  output logic       wdt_cause_o
);
  localparam int unsigned CNT_W = $clog2(WDT_MAX_MS + 1);

  logic             tick;
  logic             kick;
  logic             wd_expire;
  logic [CNT_W-1:0] wd_cnt;

  wdt_timebase #(.TICKS_PER_MS(TICKS_PER_MS)) u_tb (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  wdt_kick_detect #(.KICK_MIN_CYC(KICK_MIN_CYC), .SYNC_STAGES(2)) u_kick (
    .clk(clk), .rst(rst), .sda_i(sda_i), .kick_o(kick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .sel_i(period_sel),
    .kick_i(kick), .hold_i(cpu_rst_o), .expire_o(wd_expire), .cnt_o(wd_cnt)
  );

  wdt_rst_gen #(.RST_MS(RST_MS)) u_rgen (
    .clk(clk), .rst(rst), .tick_i(tick), .expire_i(wd_expire),
    .low_volt_i(low_volt_i), .flag_clr_i(flag_clr_i),
    .cpu_rst_o(cpu_rst_o), .rst_flag_o(rst_flag_o), .wdt_cause_o(wdt_cause_o)
  );
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    period_sel,
  input logic          low_volt_i,
  input logic          flag_clr_i,
  input logic          cpu_rst_o,
  input logic          rst_flag_o,
  input logic          wdt_cause_o,
  input logic          wd_expire,
  input logic [CW-1:0] wd_cnt
);
  // R2
  off_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (period_sel == 3'b111 && $past(period_sel) == 3'b111) |-> !wd_expire);

  // R4
  no_release_in_lv_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst_o) |-> !$past(low_volt_i));

  // R5
  lv_asserts_rst_chk: assert property (@(posedge clk) disable iff (rst)
    low_volt_i |=> cpu_rst_o);

  // R6
  wd_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_expire && !low_volt_i) |=> (cpu_rst_o && rst_flag_o && wdt_cause_o));

  // R7
  lv_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    low_volt_i |=> (rst_flag_o && !wdt_cause_o));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_flag_o && !flag_clr_i) |=> rst_flag_o);

  // R10
  cnt_held_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_o |=> (wd_cnt == '0));
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .period_sel(period_sel), .low_volt_i(low_volt_i),
  .flag_clr_i(flag_clr_i), .cpu_rst_o(cpu_rst_o), .rst_flag_o(rst_flag_o),
  .wdt_cause_o(wdt_cause_o), .wd_expire(wd_expire), .wd_cnt(wd_cnt)
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
  localparam int TPM  = 1;
  localparam int RSTM = 3;
  localparam int KMIN = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] period_sel = 3'd0;
  logic       sda_i = 1'b1;
  logic       low_volt_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       cpu_rst_o, rst_flag_o, wdt_cause_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  wdt_supervisor #(.TICKS_PER_MS(TPM), .RST_MS(RSTM), .KICK_MIN_CYC(KMIN)) u_dut (
    .clk(clk), .rst(rst), .period_sel(period_sel), .sda_i(sda_i),
    .low_volt_i(low_volt_i), .flag_clr_i(flag_clr_i),
    .cpu_rst_o(cpu_rst_o), .rst_flag_o(rst_flag_o), .wdt_cause_o(wdt_cause_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_ms(input int code);
    int t[7] = '{150, 450, 1000, 5000, 10000, 20000, 60000};
    return (code < 7) ? t[code] : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic v);
    int n = 0;
    @(negedge clk);
    while (cpu_rst_o !== v && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lv_pulse(input int n);
    low_volt_i = 1'b1;
    idle(n);
    low_volt_i = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    int t0, t1, g, k;
    void'($urandom(32'd1234));
    idle(4);
    // R11: reset state
    chk(cpu_rst_o === 1'b1, "R11 rst level", int'(cpu_rst_o), 1);
    chk(rst_flag_o === 1'b0 && wdt_cause_o === 1'b0, "R11 flags", int'(rst_flag_o), 0);
    rst = 1'b0;
    t0 = cyc;
    wait_level(1'b0);
    g = cyc - t0;
    chk(g >= RSTM - 1 && g <= RSTM + 1, "R11 power-up release", g, RSTM);

    // R1 R6 R4 R7: every period code, forced to a known start by low voltage
    for (int c = 0; c < 7; c++) begin
      period_sel = 3'(c);
      lv_pulse(2 + int'($urandom % 3));
      // R5: held after low voltage falls
      chk(cpu_rst_o === 1'b1, "R5 held after lv", int'(cpu_rst_o), 1);
      // R7: lv cause
      chk(rst_flag_o === 1'b1 && wdt_cause_o === 1'b0, "R7 lv cause", int'(wdt_cause_o), 0);
      clear_flag();
      // R8: clear
      chk(rst_flag_o === 1'b0, "R8 clear", int'(rst_flag_o), 0);
      wait_level(1'b0);
      t0 = cyc;
      wait_level(1'b1);
      g = cyc - t0;
      chk(g == exp_ms(c) * TPM, "R1 period", g, exp_ms(c) * TPM);
      chk(rst_flag_o === 1'b1 && wdt_cause_o === 1'b1, "R6 wd cause", int'(wdt_cause_o), 1);
      t1 = cyc;
      wait_level(1'b0);
      g = cyc - t1;
      chk(g == RSTM * TPM, "R4 reset width", g, RSTM * TPM);
    end

    // R8: flag holds without a clear
    idle(20 + int'($urandom % 40));
    chk(rst_flag_o === 1'b1 && wdt_cause_o === 1'b1, "R8 hold", int'(rst_flag_o), 1);

    // R5: immediate assertion by low voltage
    period_sel = 3'd0;
    idle(10);
    low_volt_i = 1'b1;
    @(negedge clk);
    chk(cpu_rst_o === 1'b1, "R5 next edge", int'(cpu_rst_o), 1);
    // R10: long low voltage (longer than the period) then a full period
    idle(400);
    low_volt_i = 1'b0;
    t0 = cyc;
    wait_level(1'b0);
    g = cyc - t0;
    chk(g >= RSTM - 1 && g <= RSTM + 1, "R5 recovery delay", g, RSTM);
    t0 = cyc;
    wait_level(1'b1);
    g = cyc - t0;
    chk(g == 150 * TPM, "R10 full period after release", g, 150 * TPM);

    // R3: short glitches ignored
    lv_pulse(2);
    wait_level(1'b0);
    t0 = cyc;
    for (int i = 0; i < 3 + int'($urandom % 4); i++) begin
      idle(5 + int'($urandom % 11));
      sda_i = 1'b0;
      idle(1 + int'($urandom % 2));
      sda_i = 1'b1;
    end
    wait_level(1'b1);
    g = cyc - t0;
    chk(g == 150 * TPM, "R3 glitch ignored", g, 150 * TPM);

    // R3: long low restarts
    for (int r = 0; r < 3; r++) begin
      lv_pulse(2);
      wait_level(1'b0);
      t0 = cyc;
      idle(100);
      k = KMIN + int'($urandom % 4);
      sda_i = 1'b0;
      idle(k);
      sda_i = 1'b1;
      wait_level(1'b1);
      g = cyc - t0;
      chk(g >= 250 && g <= 100 + k + 160, "R3 kick restart", g, 100 + KMIN + 152);
    end

    // R9: period change restarts count
    period_sel = 3'd2;
    lv_pulse(2);
    wait_level(1'b0);
    t0 = cyc;
    idle(500);
    period_sel = 3'd0;
    wait_level(1'b1);
    g = cyc - t0;
    chk(g >= 645 && g <= 655, "R9 code change", g, 650);

    // R2: disabled watchdog never fires
    period_sel = 3'd7;
    lv_pulse(2);
    wait_level(1'b0);
    clear_flag();
    idle(3000);
    chk(cpu_rst_o === 1'b0, "R2 off", int'(cpu_rst_o), 0);
    chk(rst_flag_o === 1'b0, "R2 off flag", int'(rst_flag_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule